// File: doc/BRIEF.md
# Trap and Interrupt Sequencer

This block takes a processor core into and out of its trap handlers. It watches synchronous exception strobes, decoded software-trap, system-call and return commands, a non-maskable error line and a vector of maskable external interrupt lines. When one of these is accepted it saves the core's instruction pointer, stack pointer and flags word into three dedicated context registers. It then reads the handler address from a vector table at a fixed base, with four bytes per entry. When the read returns, it loads the new instruction pointer and a flags word with supervisor mode selected and interrupts disabled. A return command reloads all three core registers from the context registers in the same cycle.

The block also obeys the stop-clock flag bit. With interrupts disabled, the core is parked in a permanent halt that only reset ends. With interrupts enabled, it waits asleep until an interrupt arrives. The core stalls while `busy` is high and applies the load strobes to its own registers.

The behaviour is a four-state machine:
- RUN: events are evaluated here.
- FETCH: the vector read is outstanding.
- HALT: stopped until reset.
- SLEEP: stopped until an interrupt wakes it.

The transitions are:
- RUN→FETCH on an accepted trap.
- RUN→RUN on a return or when nothing is pending.
- RUN→HALT on the stop bit with the enable clear.
- RUN→SLEEP on the stop bit with the enable set.
- FETCH→RUN on read-valid.
- SLEEP→FETCH on a wake interrupt.
- HALT holds until reset.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the block is in RUN: `busy`, `halted`, `asleep`, `mem_req` and all load strobes are low, and the three context outputs are zero.
- R2: In the cycle after a trap is accepted, `ctx_ip`, `ctx_sp` and `ctx_flg` hold the `cur_ip`, `cur_sp` and `cur_flg` values present in the accepting cycle.
- R3: While in FETCH, `mem_req` is high with `mem_addr` = VEC_BASE + 4·vector, held stable until `mem_rvalid`. In that same cycle `ip_load` is high, with `ip_value` = `mem_rdata`, and the block returns to RUN.
- R4: On entry, `flg_load` is asserted together with `ip_load`. `flg_value` is the saved flags with bit 16 (interrupt enable), bit 17 (user mode) and bit 19 (stop clock) cleared, and `sp_load` stays low.
- R5: A return command in supervisor mode (`cur_flg[17]`=0) asserts `ip_load`, `sp_load` and `flg_load` in the same cycle, carrying `ctx_ip`, `ctx_sp` and `ctx_flg`.
- R6: Vector numbers are fixed: divide-by-zero 0, overflow 2, invalid opcode 3, protection fault 4, page fault 5 and system call 6. A software trap uses `cmd_imm`. The system call is accepted in user mode too.
- R7: A software trap or return command issued with `cur_flg[17]`=1 takes vector 4 and restores nothing.
- R8: Priority runs from exception strobes (lowest vector first), to commands, to the non-maskable line (vector 1), to the lowest-numbered pending external line i (vector 32+i).
- R9: External lines are ignored while `cur_flg[16]`=0, and the non-maskable line is taken regardless.
- R10: With no event pending and `cur_flg[19]`=1, `cur_flg[16]`=0, the block enters HALT. `halted` then stays high, and every input is ignored until reset.
- R11: With no event pending and `cur_flg[19]`=1, `cur_flg[16]`=1, the block enters SLEEP (`asleep` high). An external or non-maskable request wakes it into a trap whose saved flags have bit 19 cleared.
- R12: `busy` is high in every state except RUN. Events arriving during FETCH are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_ip | input | XLEN | Core instruction pointer |
| cur_sp | input | XLEN | Core stack pointer |
| cur_flg | input | XLEN | Core flags word |
| exc_div0 | input | 1 | Divide-by-zero strobe |
| exc_ovf | input | 1 | Overflow strobe |
| exc_inv | input | 1 | Invalid opcode strobe |
| exc_prot | input | 1 | Protection fault strobe |
| exc_page | input | 1 | Page fault strobe |
| nmi_req | input | 1 | Non-maskable hardware error |
| irq_req | input | NUM_IRQ | Maskable external interrupt lines |
| cmd_int | input | 1 | Software trap command |
| cmd_scall | input | 1 | System call command |
| cmd_iret | input | 1 | Return-from-trap command |
| cmd_imm | input | 8 | Vector of the software trap |
| mem_req | output | 1 | Vector table read request |
| mem_addr | output | XLEN | Vector table entry address |
| mem_rdata | input | XLEN | Handler address read back |
| mem_rvalid | input | 1 | Read data valid |
| ip_load | output | 1 | Load strobe for instruction pointer |
| ip_value | output | XLEN | New instruction pointer |
| sp_load | output | 1 | Load strobe for stack pointer |
| sp_value | output | XLEN | New stack pointer |
| flg_load | output | 1 | Load strobe for flags |
| flg_value | output | XLEN | New flags word |
| busy | output | 1 | Core must stall |
| halted | output | 1 | Permanent halt |
| asleep | output | 1 | Waiting for an interrupt |
| ctx_ip | output | XLEN | Saved instruction pointer |
| ctx_sp | output | XLEN | Saved stack pointer |
| ctx_flg | output | XLEN | Saved flags |

## Verification
Single exception strobes show that each source maps to its own vector. Strobes raised together, and the non-maskable line raised alongside external lines, reveal any swap in the priority chain. The privileged commands are issued in both user and supervisor mode, which tells a real trap or restore apart from a protection fault. External lines are raised with the enable clear and then set, separating masking from acceptance. Exception strobes pulsed during an outstanding vector read must leave the sequence unchanged. The two stop-clock combinations separate halting from sleeping, and the flags saved on waking must have the stop bit clear.

// File: rtl/trap_pkg.sv
package trap_pkg;
    typedef enum logic [1:0] {
        ST_RUN,
        ST_FETCH,
        ST_HALT,
        ST_SLEEP
    } trap_state_e;

    localparam int FLG_IE   = 16;
    localparam int FLG_USER = 17;
    localparam int FLG_STOP = 19;

    localparam logic [7:0] VEC_DIV0     = 8'd0;
    localparam logic [7:0] VEC_NMI      = 8'd1;
    localparam logic [7:0] VEC_OVF      = 8'd2;
    localparam logic [7:0] VEC_INV      = 8'd3;
    localparam logic [7:0] VEC_PROT     = 8'd4;
    localparam logic [7:0] VEC_PAGE     = 8'd5;
    localparam logic [7:0] VEC_SCALL    = 8'd6;
    localparam logic [7:0] VEC_EXT_BASE = 8'd32;
endpackage

// File: rtl/trap_prio.sv
module trap_prio
    import trap_pkg::*;
#(
    parameter int NUM_IRQ = 8
) (
    input  logic [4:0]         exc,
    input  logic               cmd_int,
    input  logic               cmd_scall,
    input  logic               cmd_iret,
    input  logic [7:0]         cmd_imm,
    input  logic               user,
    input  logic               ie,
    input  logic               nmi,
    input  logic [NUM_IRQ-1:0] irq,
    output logic               take,
    output logic               do_iret,
    output logic [7:0]         vec
);
    localparam int IDXW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    // exc bit order: div0, ovf, inv, prot, page (lowest vector first)
    logic [7:0] exc_vec [5];
    assign exc_vec[0] = VEC_DIV0;
    assign exc_vec[1] = VEC_OVF;
    assign exc_vec[2] = VEC_INV;
    assign exc_vec[3] = VEC_PROT;
    assign exc_vec[4] = VEC_PAGE;

    logic [IDXW-1:0] irq_idx;
    logic            irq_any;

    always_comb begin
        irq_idx = '0;
        irq_any = 1'b0;
        for (int i = NUM_IRQ - 1; i >= 0; i--) begin
            if (irq[i]) begin
                irq_idx = IDXW'(i);
                irq_any = 1'b1;
            end
        end
    end

    logic [7:0] exc_sel;
    always_comb begin
        exc_sel = VEC_DIV0;
        for (int k = 4; k >= 0; k--) begin
            if (exc[k]) exc_sel = exc_vec[k];
        end
    end

    always_comb begin
        take    = 1'b0;
        do_iret = 1'b0;
        vec     = '0;
        if (|exc) begin
            take = 1'b1;
            vec  = exc_sel;
        end else if ((cmd_int || cmd_iret) && user) begin
            take = 1'b1;
            vec  = VEC_PROT;
        end else if (cmd_int) begin
            take = 1'b1;
            vec  = cmd_imm;
        end else if (cmd_scall) begin
            take = 1'b1;
            vec  = VEC_SCALL;
        end else if (cmd_iret) begin
            do_iret = 1'b1;
        end else if (nmi) begin
            take = 1'b1;
            vec  = VEC_NMI;
        end else if (ie && irq_any) begin
            take = 1'b1;
            vec  = VEC_EXT_BASE + 8'(irq_idx);
        end
    end
endmodule

// File: rtl/trap_ctx.sv
module trap_ctx #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save,
    input  logic [XLEN-1:0] ip_in,
    input  logic [XLEN-1:0] sp_in,
    input  logic [XLEN-1:0] flg_in,
    output logic [XLEN-1:0] ip_q,
    output logic [XLEN-1:0] sp_q,
    output logic [XLEN-1:0] flg_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ip_q  <= '0;
            sp_q  <= '0;
            flg_q <= '0;
        end else if (save) begin
            ip_q  <= ip_in;
            sp_q  <= sp_in;
            flg_q <= flg_in;
        end
    end
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
    import trap_pkg::*;
#(
    parameter int              XLEN     = 32,
    parameter int              NUM_IRQ  = 8,
    parameter logic [XLEN-1:0] VEC_BASE = 32'h0000_0100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [XLEN-1:0]    cur_ip,
    input  logic [XLEN-1:0]    cur_sp,
    input  logic [XLEN-1:0]    cur_flg,
    input  logic               exc_div0,
    input  logic               exc_ovf,
    input  logic               exc_inv,
    input  logic               exc_prot,
    input  logic               exc_page,
    input  logic               nmi_req,
    input  logic [NUM_IRQ-1:0] irq_req,
    input  logic               cmd_int,
    input  logic               cmd_scall,
    input  logic               cmd_iret,
    input  logic [7:0]         cmd_imm,
    output logic               mem_req,
    output logic [XLEN-1:0]    mem_addr,
    input  logic [XLEN-1:0]    mem_rdata,
    input  logic               mem_rvalid,
    output logic               ip_load,
    output logic [XLEN-1:0]    ip_value,
    output logic               sp_load,
    output logic [XLEN-1:0]    sp_value,
    output logic               flg_load,
    output logic [XLEN-1:0]    flg_value,
    output logic               busy,
    output logic               halted,
    output logic               asleep,
    output logic [XLEN-1:0]    ctx_ip,
    output logic [XLEN-1:0]    ctx_sp,
    output logic [XLEN-1:0]    ctx_flg
);
    localparam logic [XLEN-1:0] ENTRY_CLR =
        (XLEN'(1) << FLG_IE) | (XLEN'(1) << FLG_USER) | (XLEN'(1) << FLG_STOP);

    trap_state_e st_q, st_d;
    logic [7:0]  vec_q;
    logic        run_st, sleep_st;
    logic        take, do_iret;
    logic [7:0]  vec_sel;
    logic        accept;
    logic [XLEN-1:0] flg_save;

    assign run_st   = (st_q == ST_RUN);
    assign sleep_st = (st_q == ST_SLEEP);

    trap_prio #(.NUM_IRQ(NUM_IRQ)) u_prio (
        .exc       ({exc_page, exc_prot, exc_inv, exc_ovf, exc_div0} & {5{run_st}}),
        .cmd_int   (cmd_int   && run_st),
        .cmd_scall (cmd_scall && run_st),
        .cmd_iret  (cmd_iret  && run_st),
        .cmd_imm   (cmd_imm),
        .user      (cur_flg[FLG_USER]),
        .ie        (cur_flg[FLG_IE]),
        .nmi       (nmi_req && (run_st || sleep_st)),
        .irq       (irq_req & {NUM_IRQ{run_st || sleep_st}}),
        .take      (take),
        .do_iret   (do_iret),
        .vec       (vec_sel)
    );

    assign accept   = take && (run_st || sleep_st);
    assign flg_save = sleep_st ? (cur_flg & ~(XLEN'(1) << FLG_STOP)) : cur_flg;

    trap_ctx #(.XLEN(XLEN)) u_ctx (
        .clk    (clk),
        .rst_n  (rst_n),
        .save   (accept),
        .ip_in  (cur_ip),
        .sp_in  (cur_sp),
        .flg_in (flg_save),
        .ip_q   (ctx_ip),
        .sp_q   (ctx_sp),
        .flg_q  (ctx_flg)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_RUN;
            vec_q <= '0;
        end else begin
            st_q <= st_d;
            if (accept) vec_q <= vec_sel;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_RUN: begin
                if (take)                   st_d = ST_FETCH;
                else if (do_iret)           st_d = ST_RUN;
                else if (cur_flg[FLG_STOP]) st_d = cur_flg[FLG_IE] ? ST_SLEEP : ST_HALT;
            end
            ST_FETCH: if (mem_rvalid) st_d = ST_RUN;
            ST_HALT:  st_d = ST_HALT;
            ST_SLEEP: if (take) st_d = ST_FETCH;
            default:  st_d = ST_RUN;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_addr  = VEC_BASE + (XLEN'(vec_q) << 2);
        ip_load   = 1'b0;
        ip_value  = ctx_ip;
        sp_load   = 1'b0;
        sp_value  = ctx_sp;
        flg_load  = 1'b0;
        flg_value = ctx_flg;
        busy      = 1'b1;
        halted    = 1'b0;
        asleep    = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                busy = 1'b0;
                if (do_iret) begin
                    ip_load  = 1'b1;
                    sp_load  = 1'b1;
                    flg_load = 1'b1;
                end
            end
            ST_FETCH: begin
                mem_req = 1'b1;
                if (mem_rvalid) begin
                    ip_load   = 1'b1;
                    ip_value  = mem_rdata;
                    flg_load  = 1'b1;
                    flg_value = ctx_flg & ~ENTRY_CLR;
                end
            end
            ST_HALT:  halted = 1'b1;
            ST_SLEEP: asleep = 1'b1;
            default:  busy = 1'b1;
        endcase
    end
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic            ip_load,
    input logic            sp_load,
    input logic            flg_load,
    input logic [XLEN-1:0] flg_value,
    input logic            busy,
    input logic            halted,
    input logic            asleep
);
    // R3
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

    // R4
    entry_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ip_load && !sp_load) |-> (flg_load && !flg_value[16] && !flg_value[17] && !flg_value[19]));

    // R5
    restore_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp_load |-> (ip_load && flg_load && !mem_req));

    // R10
    halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R12
    stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req || halted || asleep) |-> busy);

    // R11
    state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_req, halted, asleep}));
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid),
    .ip_load    (ip_load),
    .sp_load    (sp_load),
    .flg_load   (flg_load),
    .flg_value  (flg_value),
    .busy       (busy),
    .halted     (halted),
    .asleep     (asleep)
);

// File: tb/trap_ctrl_tb.sv
`timescale 1ns/1ps
module trap_ctrl_tb;
    localparam int          XLEN = 32;
    localparam int          NIRQ = 8;
    localparam logic [31:0] BASE = 32'h0000_0100;
    localparam int          LAT  = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n;
    logic [31:0] cur_ip, cur_sp, cur_flg;
    logic exc_div0, exc_ovf, exc_inv, exc_prot, exc_page, nmi_req;
    logic [NIRQ-1:0] irq_req;
    logic cmd_int, cmd_scall, cmd_iret;
    logic [7:0] cmd_imm;
    logic mem_req, mem_rvalid;
    logic [31:0] mem_addr, mem_rdata;
    logic ip_load, sp_load, flg_load, busy, halted, asleep;
    logic [31:0] ip_value, sp_value, flg_value, ctx_ip, ctx_sp, ctx_flg;

    trap_ctrl #(.XLEN(XLEN), .NUM_IRQ(NIRQ), .VEC_BASE(BASE)) u_dut (
        .clk(clk), .rst_n(rst_n), .cur_ip(cur_ip), .cur_sp(cur_sp), .cur_flg(cur_flg),
        .exc_div0(exc_div0), .exc_ovf(exc_ovf), .exc_inv(exc_inv), .exc_prot(exc_prot),
        .exc_page(exc_page), .nmi_req(nmi_req), .irq_req(irq_req), .cmd_int(cmd_int),
        .cmd_scall(cmd_scall), .cmd_iret(cmd_iret), .cmd_imm(cmd_imm), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
        .ip_load(ip_load), .ip_value(ip_value), .sp_load(sp_load), .sp_value(sp_value),
        .flg_load(flg_load), .flg_value(flg_value), .busy(busy), .halted(halted),
        .asleep(asleep), .ctx_ip(ctx_ip), .ctx_sp(ctx_sp), .ctx_flg(ctx_flg)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tag = "R1";

    // reference model state: 0 run, 1 fetch, 2 halt, 3 sleep
    int m_st = 0;
    int m_vec = 0;
    logic [31:0] m_c0 = 0, m_c1 = 0, m_c2 = 0;
    int lat = 0;

    function automatic logic [31:0] handler(int v);
        return 32'hA000_0000 | (32'(v) << 4);
    endfunction

    // -1 nothing, -2 restore, otherwise vector
    function automatic int pick();
        bit user = cur_flg[17];
        bit ie = cur_flg[16];
        if (m_st == 0) begin
            if (exc_div0) return 0;
            if (exc_ovf)  return 2;
            if (exc_inv)  return 3;
            if (exc_prot) return 4;
            if (exc_page) return 5;
            if ((cmd_int || cmd_iret) && user) return 4;
            if (cmd_int)   return int'(cmd_imm);
            if (cmd_scall) return 6;
            if (cmd_iret)  return -2;
        end
        if (m_st == 0 || m_st == 3) begin
            if (nmi_req) return 1;
            if (ie) for (int i = 0; i < NIRQ; i++) if (irq_req[i]) return 32 + i;
        end
        return -1;
    endfunction

    task automatic cmp(string name, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, name, act, exp);
        end
    endtask

    task automatic clear_in();
        exc_div0 = 0; exc_ovf = 0; exc_inv = 0; exc_prot = 0; exc_page = 0;
        nmi_req = 0; irq_req = '0; cmd_int = 0; cmd_scall = 0; cmd_iret = 0; cmd_imm = 0;
    endtask

    task automatic step();
        int p;
        logic [31:0] clr;
        @(negedge clk);
        #1;
        mem_rvalid = mem_req && (lat == LAT);
        mem_rdata  = mem_req ? handler(int'((mem_addr - BASE) >> 2)) : 32'h0;
        #1;
        p = pick();
        clr = ~((32'h1 << 16) | (32'h1 << 17) | (32'h1 << 19));
        cmp("busy", 32'(busy), 32'(m_st != 0));
        cmp("halted", 32'(halted), 32'(m_st == 2));
        cmp("asleep", 32'(asleep), 32'(m_st == 3));
        cmp("mem_req", 32'(mem_req), 32'(m_st == 1));
        if (m_st == 1) cmp("mem_addr", mem_addr, BASE + 32'(m_vec) * 4);
        cmp("ip_load", 32'(ip_load), 32'((m_st == 1 && mem_rvalid) || (m_st == 0 && p == -2)));
        cmp("sp_load", 32'(sp_load), 32'(m_st == 0 && p == -2));
        cmp("flg_load", 32'(flg_load), 32'((m_st == 1 && mem_rvalid) || (m_st == 0 && p == -2)));
        if (m_st == 1 && mem_rvalid) begin
            cmp("ip_value", ip_value, handler(m_vec));
            cmp("flg_value", flg_value, m_c2 & clr);
        end
        if (m_st == 0 && p == -2) begin
            cmp("ip_value", ip_value, m_c0);
            cmp("sp_value", sp_value, m_c1);
            cmp("flg_value", flg_value, m_c2);
        end
        cmp("ctx_ip", ctx_ip, m_c0);
        cmp("ctx_sp", ctx_sp, m_c1);
        cmp("ctx_flg", ctx_flg, m_c2);
        @(posedge clk);
        if (!rst_n) begin
            m_st = 0; m_vec = 0; m_c0 = 0; m_c1 = 0; m_c2 = 0; lat = 0;
        end else begin
            if ((m_st == 0 || m_st == 3) && p >= 0) begin
                m_c0 = cur_ip; m_c1 = cur_sp;
                m_c2 = (m_st == 3) ? (cur_flg & ~(32'h1 << 19)) : cur_flg;
                m_vec = p; m_st = 1;
            end else if (m_st == 0 && p == -1 && cur_flg[19]) begin
                m_st = cur_flg[16] ? 3 : 2;
            end else if (m_st == 1 && mem_rvalid) begin
                m_st = 0;
            end
            lat = (mem_req && !mem_rvalid) ? lat + 1 : 0;
        end
        #1;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    // one-cycle pulse then idle until the entry completes
    task automatic settle();
        step();
        clear_in();
        run(LAT + 3);
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; clear_in();
        mem_rvalid = 0; mem_rdata = 0;
        cur_ip = 32'h40; cur_sp = 32'h800; cur_flg = 32'h0001_0005;
        tag = "R1"; run(3);
        rst_n = 1; run(2);

        tag = "R2_R3_R4_R6_div0";  exc_div0 = 1; settle();
        tag = "R8_exc_order";      cur_ip = 32'h44; exc_ovf = 1; exc_inv = 1; exc_page = 1; settle();
        tag = "R6_inv";            exc_inv = 1; settle();
        tag = "R6_page";           cur_sp = 32'h7F0; exc_page = 1; settle();
        tag = "R7_user_int";       cur_flg = 32'h0003_0000; cmd_int = 1; cmd_imm = 8'h45; settle();
        tag = "R6_user_scall";     cmd_scall = 1; settle();
        tag = "R7_user_iret";      cmd_iret = 1; settle();
        tag = "R6_super_int";      cur_flg = 32'h0001_0002; cur_ip = 32'h120; cmd_int = 1; cmd_imm = 8'h45; settle();
        tag = "R5_iret";           cmd_iret = 1; step(); clear_in(); run(2);
        tag = "R8_cmd_vs_nmi";     cmd_scall = 1; nmi_req = 1; settle();
        tag = "R8_nmi_vs_irq";     nmi_req = 1; irq_req = 8'b0010_1000; settle();
        tag = "R8_low_irq";        irq_req = 8'b1010_1000; settle();
        tag = "R9_masked";         cur_flg = 32'h0000_0000; irq_req = 8'h81; run(4);
        tag = "R9_nmi_unmasked";   nmi_req = 1; settle();
        tag = "R12_fetch_ignore";  cur_flg = 32'h0001_0000; exc_ovf = 1; step(); clear_in();
        exc_prot = 1; nmi_req = 1; step(); clear_in(); run(LAT + 2);
        tag = "R11_sleep";         cur_flg = 32'h0009_0000; cur_ip = 32'h300; run(4);
        irq_req = 8'h04; settle();
        tag = "R11_wake_iret";     cur_flg = 32'h0000_0000; cmd_iret = 1; step(); clear_in(); run(2);
        tag = "R10_halt";          cur_flg = 32'h0008_0000; run(3);
        nmi_req = 1; exc_div0 = 1; cmd_iret = 1; irq_req = 8'hFF; run(4); clear_in(); run(2);
        tag = "R1_rereset";        rst_n = 0; cur_flg = 32'h0001_0000; run(2); rst_n = 1; run(2);
        tag = "R3_after_reset";    exc_prot = 1; settle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule